// File: doc/BRIEF.md
# Ragged-Column Final Adder

This block is the last stage of a multi-operand summation. An upstream compressor hands it a bit matrix that has been reduced only partly. The columns do not form full rows, and their heights vary from one column to the next. The block turns that matrix into one binary number. Each column holds bits of equal weight 2^c. A column is placed on one of three element kinds: a plain bit copy, a full adder, or a ternary element. The kind follows from how many bits the column holds and how many carries arrive from the column below.

A ternary element uses two carries. It first folds three of the column's own bits in a lookup stage. The secondary carry that comes out of this fold goes one column up over ordinary routing. The remaining bits then enter a ripple stage with the fast chain carry. The secondary carry is formed only from the column's own bits, so secondary carries never ripple through several columns.

The height profile is a parameter. It packs four bits per column, with the lowest nibble for column 0. The element kind of each column and the carries it receives are worked out at elaboration. The profile is legal only if the first column holds at most four bits and every later column holds at most four bits plus incoming secondary carries. Any other profile stops elaboration with an error, which means the compressor upstream needs another stage. The sum is registered once before it leaves the block.

Top module: `rtfa_top`

## Requirements
- R1: One clock after the column bits are applied, `sum_q` equals the arithmetic sum of every input bit weighted by 2^c, where c is the index of the bit's column.
- R2: While `rst_n` is low, `sum_q` reads zero, including a reset asserted in the middle of operation with all inputs high.
- R3: The first column accepts four bits, and the fourth bit is fed into the chain carry-in. With only column 0 driven, the result equals the number of its bits that are set, from 0 to 4.
- R4: The secondary carry out of a ternary column depends only on that column's own bits and is set only when at least two of them are set. Sums stay exact when ternary columns follow one another.
- R5: Each column uses a bit copy when it has at most one input (own bits plus incoming carries), a full adder for two or three inputs, and a ternary element for four or more. Every column conserves value: its inputs equal its sum bit plus twice its outgoing carries. A copy column never sees more than one set input.
- R6: Column c occupies `col_bits` starting at the sum of the heights of columns below c. With the default profile (heights 4,3,2,3,1), columns 0 through 4 sit at bits [3:0], [6:4], [8:7], [11:9] and [12]. Any single set bit yields 2^c.
- R7: The output width is the smallest width that holds the largest possible sum (58 for the default profile, so 6 bits). The all-ones input yields that maximum, and no carry leaves the top column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| col_bits | input | NBITS (13) | Column bits packed column by column, lowest column first |
| sum_q | output | SW (6) | Registered binary sum of the weighted columns |

## Verification
Any wrong element choice, carry routing or bit offset changes the value of at least one input pattern. Because the block has a single register, that error appears in `sum_q` on the very next cycle after the pattern is applied. The default profile has only 13 input bits, so every input pattern is applied and compared with a weighted sum computed in the bench. A secondary carry wrongly coupled to its incoming carry, or a carry dropped at the top, therefore shows up as a wrong sum one cycle later. Internally, per-column value balance and carry-origin properties point to the exact column that first goes wrong.

// File: rtl/rtfa_pkg.sv
package rtfa_pkg;

  localparam int MAXC = 16;
  localparam int HW   = 4;

  typedef enum logic [1:0] {EL_COPY = 2'd0, EL_FULL = 2'd1, EL_TERN = 2'd2} elem_e;
  typedef logic [MAXC*HW-1:0] prof_t;
  typedef logic [255:0]       bitv_t;

  function automatic int col_h(prof_t p, int c);
    if (c < 0 || c >= MAXC) return 0;
    return int'(p[c*HW +: HW]);
  endfunction

  function automatic prof_t keep_cols(prof_t p, int n);
    prof_t r = '0;
    for (int i = 0; i < MAXC; i++)
      if (i < n) r[i*HW +: HW] = p[i*HW +: HW];
    return r;
  endfunction

  function automatic elem_e pick(int inputs);
    if (inputs <= 1) return EL_COPY;
    if (inputs <= 3) return EL_FULL;
    return EL_TERN;
  endfunction

  function automatic elem_e col_kind(prof_t p, int c);
    elem_e k    = EL_COPY;
    int    prim = 0;
    int    sec  = 0;
    for (int i = 0; i < MAXC; i++)
      if (i <= c) begin
        k    = pick(col_h(p, i) + prim + sec);
        prim = (k != EL_COPY) ? 1 : 0;
        sec  = (k == EL_TERN) ? 1 : 0;
      end
    return k;
  endfunction

  function automatic bit prim_in(prof_t p, int c);
    return (c > 0) && (col_kind(p, c - 1) != EL_COPY);
  endfunction

  function automatic bit sec_in(prof_t p, int c);
    return (c > 0) && (col_kind(p, c - 1) == EL_TERN);
  endfunction

  function automatic bit prof_fits(prof_t p, int n);
    bit ok = 1'b1;
    for (int i = 0; i < MAXC; i++)
      if (i < n) begin
        if (i == 0) ok = ok && (col_h(p, i) <= 4);
        else        ok = ok && (col_h(p, i) + int'(sec_in(p, i)) <= 4);
      end
    return ok;
  endfunction

  function automatic int col_off(prof_t p, int c);
    int acc = 0;
    for (int i = 0; i < MAXC; i++)
      if (i < c) acc += col_h(p, i);
    return acc;
  endfunction

  function automatic longint max_total(prof_t p, int n);
    longint acc = 0;
    for (int i = 0; i < MAXC; i++)
      if (i < n) acc += longint'(col_h(p, i)) << i;
    return acc;
  endfunction

  function automatic int sum_bits(longint v);
    int n = 1;
    for (int b = 1; b < 62; b++)
      if (v >= (longint'(1) << b)) n = b + 1;
    return n;
  endfunction

  function automatic longint weigh(bitv_t v, prof_t p, int n);
    longint acc = 0;
    int     pos = 0;
    for (int c = 0; c < MAXC; c++)
      if (c < n)
        for (int j = 0; j < HW + 11; j++)
          if (j < col_h(p, c)) begin
            if (v[pos]) acc += longint'(1) << c;
            pos++;
          end
    return acc;
  endfunction

  function automatic logic [1:0] add3(logic a, logic b, logic c);
    return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

endpackage

// File: rtl/rtfa_elem.sv
module rtfa_elem
  import rtfa_pkg::*;
#(
  parameter int    H     = 1,
  parameter elem_e KIND  = EL_COPY,
  parameter bit    PIN   = 1'b0,
  parameter bit    SIN   = 1'b0,
  parameter bit    FIRST = 1'b0,
  localparam int   HB    = (H > 0) ? H : 1
) (
  input  logic [HB-1:0] bits,
  input  logic          cp_in,
  input  logic          cs_in,
  output logic          sum,
  output logic          cp_out,
  output logic          cs_out
);

  logic [3:0] own;
  logic       unused_in;

  if (H > 4) begin : g_too_tall
    $error("rtfa_elem: column taller than four bits");
  end

  for (genvar j = 0; j < 4; j++) begin : g_own
    if (j < H) begin : g_b
      assign own[j] = bits[j];
    end else begin : g_z
      assign own[j] = 1'b0;
    end
  end

  assign unused_in = ^{cp_in, cs_in, own};

  if (KIND == EL_TERN) begin : g_tern
    logic [1:0] lut_r;
    logic [1:0] chn_r;
    logic       side;
    logic       chin;
    assign lut_r  = add3(own[0], own[1], own[2]);
    assign side   = SIN ? cs_in : (FIRST ? 1'b0 : own[3]);
    assign chin   = FIRST ? own[3] : (PIN ? cp_in : 1'b0);
    assign chn_r  = add3(lut_r[0], side, chin);
    assign sum    = chn_r[0];
    assign cp_out = chn_r[1];
    assign cs_out = lut_r[1];
  end else if (KIND == EL_FULL) begin : g_full
    logic [1:0] cnt;
    assign cnt = 2'(own[0]) + 2'(own[1]) + 2'(own[2]) + 2'(own[3])
               + 2'(PIN & cp_in) + 2'(SIN & cs_in);
    assign sum    = cnt[0];
    assign cp_out = cnt[1];
    assign cs_out = 1'b0;
  end else begin : g_copy
    assign sum    = |{own, PIN & cp_in, SIN & cs_in};
    assign cp_out = 1'b0;
    assign cs_out = 1'b0;
  end

endmodule

// File: rtl/rtfa_outreg.sv
module rtfa_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/rtfa_top.sv
module rtfa_top
  import rtfa_pkg::*;
#(
  parameter int    NCOL  = 5,
  parameter prof_t PROF  = prof_t'(64'h13234),
  localparam prof_t PRF  = keep_cols(PROF, NCOL),
  localparam int   NBITS = col_off(PRF, NCOL),
  localparam longint MAXV = max_total(PRF, NCOL),
  localparam int   SW    = sum_bits(MAXV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] col_bits,
  output logic [SW-1:0]    sum_q
);

  logic [SW:0]   cpv;
  logic [SW:0]   csv;
  logic [SW-1:0] adder_sum;

  if (!prof_fits(PRF, NCOL) || SW < NCOL || NCOL > MAXC) begin : g_bad_profile
    $error("rtfa_top: column profile does not fit the final adder");
  end

  assign cpv[0] = 1'b0;
  assign csv[0] = 1'b0;

  for (genvar c = 0; c < SW; c++) begin : g_col
    localparam int HC = col_h(PRF, c);
    localparam int OF = col_off(PRF, c);
    localparam elem_e KC = col_kind(PRF, c);
    logic [((HC > 0) ? HC : 1)-1:0] cb;

    if (HC > 0) begin : g_tap
      assign cb = col_bits[OF +: HC];
    end else begin : g_none
      assign cb = 1'b0;
    end

    rtfa_elem #(
      .H    (HC),
      .KIND (KC),
      .PIN  (prim_in(PRF, c)),
      .SIN  (sec_in(PRF, c)),
      .FIRST(c == 0)
    ) u_elem (
      .bits  (cb),
      .cp_in (cpv[c]),
      .cs_in (csv[c]),
      .sum   (adder_sum[c]),
      .cp_out(cpv[c+1]),
      .cs_out(csv[c+1])
    );

    // R5
    col_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(cb) + int'(cpv[c]) + int'(csv[c]))
        == (int'(adder_sum[c]) + 2 * (int'(cpv[c+1]) + int'(csv[c+1]))))
      else $error("column %0d loses value", c);

    // R4
    sec_carry_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csv[c+1] |-> ($countones(cb) >= 2))
      else $error("secondary carry of column %0d not from own bits", c);

    if (KC == EL_COPY) begin : g_copy_chk
      // R5
      copy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cb, cpv[c], csv[c]}) <= 1)
        else $error("copy column %0d sees several inputs", c);
    end
  end

  rtfa_outreg #(.W(SW)) u_outreg (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (adder_sum),
    .q    (sum_q)
  );

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpv[SW] && !csv[SW])
    else $error("carry left the top column");

  // R1
  sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (sum_q == SW'(weigh(bitv_t'($past(col_bits)), PRF, NCOL))))
    else $error("registered sum differs from weighted input");

endmodule

// File: tb/test_rtfa_top.sv
module test_rtfa_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 13;
  localparam int SWB  = 6;
  localparam int NC   = 5;
  localparam int HGT [NC] = '{4, 3, 2, 3, 1};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NB-1:0]  col_bits = '0;
  logic [SWB-1:0] sum_q;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtfa_top i_rtfa_top (
    .clk     (clk),
    .rst_n   (rst_n),
    .col_bits(col_bits),
    .sum_q   (sum_q)
  );

  function automatic int ref_sum(logic [NB-1:0] v);
    int pos = 0;
    int acc = 0;
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < HGT[c]; j++) begin
        acc += int'(v[pos]) * (1 << c);
        pos++;
      end
    return acc;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: sum_q=%0d expected %0d (col_bits=%b)", tag, act, exp, col_bits);
    end
  endtask

  task automatic apply_check(string tag, logic [NB-1:0] v);
    col_bits = v;
    @(negedge clk);
    check(tag, int'(sum_q), ref_sum(v));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    col_bits = '1;
    repeat (3) @(negedge clk);
    check("R2", int'(sum_q), 0);
    rst_n = 1'b1;

    // R3: column 0 alone, 0..4 bits set
    apply_check("R3", 13'h0000);
    apply_check("R3", 13'h0001);
    apply_check("R3", 13'h0003);
    apply_check("R3", 13'h0007);
    apply_check("R3", 13'h000F);

    // R6: every single bit lands at its column weight
    for (int b = 0; b < NB; b++) apply_check("R6", NB'(1) << b);

    // R4: chained ternary columns with secondary carries in flight
    apply_check("R4", 13'h0077);
    apply_check("R4", 13'h01FF);
    apply_check("R4", 13'h0E73);

    // R5: carries fed into the full-adder and copy columns at the top
    apply_check("R5", 13'h1000);
    apply_check("R5", 13'h1E00);
    apply_check("R5", 13'h1F80);

    // R7: all-ones gives the maximum
    col_bits = '1;
    @(negedge clk);
    check("R7", int'(sum_q), 58);

    // R1: every input pattern
    for (int v = 0; v < (1 << NB); v++) apply_check("R1", NB'(v));

    // R2: reset in mid-run with all inputs high
    col_bits = '1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R2", int'(sum_q), 0);
    rst_n = 1'b1;
    apply_check("R2", 13'h1555);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule